// File: doc/BRIEF.md
# Decade Twisted-Ring Counter with Time-Slot Decoder

This block counts clock edges modulo ten with a five-bit twisted ring. On each step the ring shifts its bits up by one place and feeds the inverted top bit back into the bottom. The ten legal ring patterns drive ten time-slot lines. Exactly one line is high in any legal count. Each line is decoded from one pair of neighbouring ring bits, so moving from one count to the next changes only one ring bit, and no other line can glitch high during the change.

A hold input freezes the count while it is high. A synchronous reset returns the count to zero. A preset port writes any five-bit pattern straight into the ring, including the 22 patterns that are not legal. A ring that is in an illegal pattern returns to count zero on its next enabled step. A carry line is high for the first half of each ten-count cycle and low for the second half. Slot lines and carry come from registers that load from the decode of the next ring value, so they change in the same cycle as the ring.

Top module: `johnson_decade`

## Requirements
- R1: When `rst` is high at a rising edge, the next outputs are `slot` = 10'b0000000001 (count 0) and `carry` = 1. Reset wins over `seed_en` and over `hold`.
- R2: With `rst`, `seed_en` and `hold` all low, each rising edge moves a legal count k to (k+1) mod 10. The high slot line moves from bit k to bit (k+1) mod 10.
- R3: With `hold` high and `rst` and `seed_en` low, a rising edge leaves `slot` and `carry` unchanged.
- R4: In a legal count k, only `slot[k]` is high. While the counter advances, each slot line stays high for exactly one clock period.
- R5: `carry` is high in counts 0 to 4 and low in counts 5 to 9. It therefore completes one period every ten enabled clocks.
- R6: When `seed_en` is high and `rst` is low, the ring loads `seed_val` at the edge, even if `hold` is high. Count k has ring value 2^k−1 for k = 0..5, and 31 − (2^(k−5) − 1) for k = 6..9 (bit 0 is the ring input stage).
- R7: A seeded ring pattern outside the ten legal values drives a number of high slot lines other than one.
- R8: An illegal ring pattern is kept while `hold` is high. On the next enabled step it returns to count 0 (`slot` = 10'b0000000001, `carry` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to count 0 |
| hold | input | 1 | High: counting is frozen |
| seed_en | input | 1 | High: load `seed_val` into the ring |
| seed_val | input | STAGES | Ring pattern to load |
| slot | output | 2*STAGES | Registered one-hot time-slot lines |
| carry | output | 1 | Registered carry, high in the first half of the cycle |

## Verification
The checker tests the following on every clock: the value after reset, that hold freezes the outputs, that an enabled step rotates a one-hot slot vector by one place, that carry agrees with the lower half of the slot lines, and that any non-one-hot slot vector becomes count 0 on an enabled step. The bench covers the behaviour that needs chosen stimulus. It steps through several full cycles. It presets every one of the 32 ring patterns and sorts each one, using its own list of legal values, as a count or as an illegal pattern. It holds illegal patterns under `hold` and then releases them. It also checks that reset and preset take priority when they arrive together with hold.

// File: rtl/jdec_pkg.sv
`timescale 1ns/1ps
package jdec_pkg;
  typedef enum logic [1:0] {
    RING_HOLD  = 2'd0,
    RING_STEP  = 2'd1,
    RING_LOAD  = 2'd2,
    RING_CLEAR = 2'd3
  } ring_op_e;
endpackage

// File: rtl/jdec_ctrl.sv
`timescale 1ns/1ps
// Chooses what the ring does at the next edge: reset, then preset, then hold, then step.
module jdec_ctrl
  import jdec_pkg::*;
(
  input  logic     rst,
  input  logic     hold,
  input  logic     seed_en,
  output ring_op_e op
);
  always_comb begin
    if (rst)          op = RING_CLEAR;
    else if (seed_en) op = RING_LOAD;
    else if (hold)    op = RING_HOLD;
    else              op = RING_STEP;
  end
endmodule

// File: rtl/jdec_ring.sv
`timescale 1ns/1ps
// Twisted ring register. Its next-state logic also catches illegal patterns.
module jdec_ring
  import jdec_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  ring_op_e          op,
  input  logic [STAGES-1:0] seed_val,
  output logic [STAGES-1:0] ring_q,
  output logic [STAGES-1:0] ring_d
);
  localparam int EDGES = STAGES - 1;

  logic [EDGES-1:0] edge_mark;
  logic             legal;

  // A legal pattern has at most one place where neighbouring bits differ.
  assign edge_mark = ring_q[STAGES-1:1] ^ ring_q[STAGES-2:0];
  assign legal     = ($countones(edge_mark) <= 1);

  always_comb begin
    unique case (op)
      RING_CLEAR: ring_d = '0;
      RING_LOAD:  ring_d = seed_val;
      RING_STEP:  ring_d = legal ? {ring_q[STAGES-2:0], ~ring_q[STAGES-1]} : '0;
      default:    ring_d = ring_q;
    endcase
  end

  always_ff @(posedge clk) begin
    ring_q <= ring_d;
  end
endmodule

// File: rtl/jdec_decode.sv
`timescale 1ns/1ps
// Each slot line is a two-input gate on neighbouring ring bits.
module jdec_decode #(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0]   ring,
  output logic [2*STAGES-1:0] slot,
  output logic                carry
);
  assign slot[0]      = ~ring[0] & ~ring[STAGES-1];
  assign slot[STAGES] =  ring[0] &  ring[STAGES-1];

  for (genvar k = 1; k < STAGES; k++) begin : g_pair
    assign slot[k]        =  ring[k-1] & ~ring[k];
    assign slot[STAGES+k] = ~ring[k-1] &  ring[k];
  end

  assign carry = ~ring[STAGES-1];
endmodule

// File: rtl/johnson_decade.sv
`timescale 1ns/1ps
module johnson_decade
  import jdec_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hold,
  input  logic                seed_en,
  input  logic [STAGES-1:0]   seed_val,
  output logic [2*STAGES-1:0] slot,
  output logic                carry
);
  localparam int SLOTS = 2 * STAGES;

  ring_op_e          op;
  logic [STAGES-1:0] ring_q;
  logic [STAGES-1:0] ring_d;
  logic [SLOTS-1:0]  slot_d;
  logic              carry_d;

  jdec_ctrl u_ctrl (
    .rst     (rst),
    .hold    (hold),
    .seed_en (seed_en),
    .op      (op)
  );

  jdec_ring #(.STAGES(STAGES)) u_ring (
    .clk      (clk),
    .op       (op),
    .seed_val (seed_val),
    .ring_q   (ring_q),
    .ring_d   (ring_d)
  );

  // Decode the next ring value so the output registers change together with the ring.
  jdec_decode #(.STAGES(STAGES)) u_dec (
    .ring  (ring_d),
    .slot  (slot_d),
    .carry (carry_d)
  );

  always_ff @(posedge clk) begin
    slot  <= slot_d;
    carry <= carry_d;
  end
endmodule

// File: rtl/johnson_decade_chk.sv
`timescale 1ns/1ps
module johnson_decade_chk #(
  parameter int STAGES = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                hold,
  input logic                seed_en,
  input logic [2*STAGES-1:0] slot,
  input logic                carry
);
  localparam int SLOTS = 2 * STAGES;

  logic step;
  assign step = !rst && !seed_en && !hold;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (slot == SLOTS'(1)) && carry); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (hold && !seed_en) |=> ($stable(slot) && $stable(carry))); // R3

  AST_STEP_ROTATE: assert property (@(posedge clk) disable iff (rst)
    (step && $onehot(slot)) |=> (slot == {$past(slot[SLOTS-2:0]), $past(slot[SLOTS-1])})); // R2

  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    step |=> $onehot(slot)); // R4

  AST_CARRY_HALF: assert property (@(posedge clk) disable iff (rst)
    $onehot(slot) |-> (carry == (|slot[STAGES-1:0]))); // R5

  AST_RECOVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (step && !$onehot(slot)) |=> (slot == SLOTS'(1)) && carry); // R8
endmodule

bind johnson_decade johnson_decade_chk #(.STAGES(STAGES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .hold    (hold),
  .seed_en (seed_en),
  .slot    (slot),
  .carry   (carry)
);

// File: tb/johnson_decade_bench.sv
`timescale 1ns/1ps
module johnson_decade_bench;
  localparam int STAGES = 5;
  localparam int SLOTS  = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              hold = 1'b0;
  logic              seed_en = 1'b0;
  logic [STAGES-1:0] seed_val = '0;
  logic [SLOTS-1:0]  slot;
  logic              carry;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  johnson_decade #(.STAGES(STAGES)) u_johnson_decade (
    .clk(clk), .rst(rst), .hold(hold), .seed_en(seed_en),
    .seed_val(seed_val), .slot(slot), .carry(carry)
  );

  function automatic logic [STAGES-1:0] ring_of(input int k);
    if (k <= 5) return STAGES'((1 << k) - 1);
    return STAGES'(31 - ((1 << (k - 5)) - 1));
  endfunction

  function automatic int count_of(input logic [STAGES-1:0] v);
    for (int k = 0; k < SLOTS; k++) if (ring_of(k) == v) return k;
    return -1;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [SLOTS-1:0] exp_slot, input logic exp_carry);
    checks++;
    if (slot !== exp_slot || carry !== exp_carry) begin
      errors++;
      $display("FAIL %s: slot=%b carry=%b expected slot=%b carry=%b", req, slot, carry, exp_slot, exp_carry);
    end
  endtask

  task automatic chk_count(input string req, input int k);
    chk(req, SLOTS'(1) << k, k < 5);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [SLOTS-1:0] snap;
    // R1: reset overrides preset and hold
    @(negedge clk);
    rst = 1; hold = 1; seed_en = 1; seed_val = 5'b10101;
    tick();
    chk_count("R1 reset", 0);
    rst = 0; seed_en = 0; hold = 0;
    // R2 R4 R5: advance through 2.5 cycles
    for (int n = 1; n <= 25; n++) begin
      tick();
      chk_count("R2/R4/R5 advance", n % 10);
    end
    // R3: hold freezes the count (count is now 5)
    hold = 1;
    for (int n = 0; n < 3; n++) begin
      tick();
      chk_count("R3 hold", 5);
    end
    hold = 0;
    tick();
    chk_count("R2 resume", 6);
    // R6: preset each legal count under hold, then step
    for (int k = 0; k < SLOTS; k++) begin
      hold = 1; seed_en = 1; seed_val = ring_of(k);
      tick();
      chk_count("R6 preset", k);
      seed_en = 0; hold = 0;
      tick();
      chk_count("R6 step after preset", (k + 1) % 10);
    end
    // R7 R8: every ring pattern
    for (int v = 0; v < 32; v++) begin
      int k;
      k = count_of(STAGES'(v));
      seed_en = 1; seed_val = STAGES'(v);
      tick();
      seed_en = 0;
      if (k >= 0) begin
        chk_count("R6 sweep legal", k);
        tick();
        chk_count("R2 sweep step", (k + 1) % 10);
      end else begin
        checks++;
        if ($countones(slot) == 1) begin
          errors++;
          $display("FAIL R7 pattern %b: slot=%b expected not one-hot", v[4:0], slot);
        end
        snap = slot;
        hold = 1;
        tick();
        chk("R8 illegal held", snap, carry);
        checks++;
        if (slot !== snap) begin
          errors++;
          $display("FAIL R8 hold: slot=%b expected %b", slot, snap);
        end
        hold = 0;
        tick();
        chk_count("R8 recover", 0);
      end
    end
    // R1: reset in the middle of a count
    for (int n = 0; n < 7; n++) tick();
    rst = 1;
    tick();
    chk_count("R1 mid reset", 0);
    rst = 0;
    tick();
    chk_count("R2 after reset", 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule